// File: doc/BRIEF.md
# Standby Power-State and Output-Level Controller

This block sits in the timing generator of an image-sensor front end. Software uses a small synchronous write port to select full-power operation or one of three standby depths. The block turns that choice, together with a live output-control pin, into per-pin drive decisions:

- output enable (an enable of 0 means high impedance),
- a forced level, or a "keep running" flag, for each pin group: horizontal clocks, the HL and reset-gate pins, the VD/HD sync pair, the data clock, the data bus, the vertical drivers and the general-purpose outputs.

It also raises the enable flags for the analog front end, the timing core and the crystal oscillator.

Priority is split between the two controls. The deepest standby level overrides the output-control pin. A low output-control pin overrides the two lighter standby levels and normal mode. Leaving a standby level that stops the timing core or the oscillator starts a settling interval. A timing-core reset requested inside that interval is refused and flagged. The interval is derived from the clock frequency, given in kHz, and a time in microseconds.

The block has no streaming data path. Every port is a plain level or a one-cycle strobe, so there is no back-pressure. A write is accepted whenever `wr_en` is high at a rising clock edge.

Top module: `standby_out_ctrl`

## Requirements
- R1: The standby field takes its value from address 0, bits [1:0]. The power flags follow it:
  - 00: front end, core and oscillator all on.
  - 01: front end off, core and oscillator on.
  - 10: front end and core off, oscillator on.
  - 11: all three off.
  - `clko_run` equals the oscillator flag.
- R2: At level 11, whatever `out_ctl` is:
  - every horizontal clock, HL and the reset gate are high impedance (enable 0);
  - sync, data clock and data bus are held low (`sync_run`=0, `sync_lvl`=0, `dclk_run`=0, `data_low`=1).
- R3: Vertical outputs are forced (`v_force`=1) in every state except normal. The level comes from the deep-standby vertical polarity register (address 2) at level 11. Otherwise it comes from the light vertical polarity register (address 1). In normal operation `v_force`=0 and `v_lvl`=0.
- R4: With the field not 11 and `out_ctl` low:
  - horizontal clocks are enabled at fixed levels, low on even indices and high on odd indices;
  - HL and the reset gate are enabled and low;
  - `h_min_drive`=1 and `data_low`=1;
  - the data clock runs (`dclk_run`=1);
  - `sync_lvl` equals the sync polarity bit (address 6, bit 0), with `sync_run`=0.
- R5: At levels 01 or 10 with `out_ctl` high, outputs match R4 with two differences: `sync_lvl`=0 and `dclk_run`=0.
- R6: `gpo_oe` equals the direction register (address 4) and is all zeros after reset. The GPO level is forced from address 3 in every state except normal. In normal operation `gpo_force`=0 and `gpo_lvl`=0.
- R7: Writing 00 to the standby field while it holds 10 or 11 loads a wait of CLK_KHZ*SETTLE_US/1000 cycles, which counts down by one each clock. A core-reset request that arrives while the wait is non-zero pulses `rst_err` for one cycle and produces no `core_rst`.
- R8: A write with bit 0 = 0 to address 5 arms the reset sequence. A later write with bit 0 = 1 produces a one-cycle `core_rst` in the cycle after the write edge, provided the wait has expired, and then disarms. A bit-0 = 1 write while unarmed does nothing.
- R9: A register write changes the outputs from the clock edge that accepts it, not before. Writes to address 7 change nothing.
- R10: With the field at 00 and `out_ctl` high:
  - all horizontal, HL and reset-gate pins are enabled;
  - sync and data clock run;
  - nothing is forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Register write data |
| out_ctl | input | 1 | Output control; low forces fixed output states |
| fe_en | output | 1 | Analog front-end enable |
| tcore_en | output | 1 | Timing-core enable |
| osc_en | output | 1 | Oscillator enable |
| clko_run | output | 1 | Clock output running (else low) |
| h_oe | output | NH | Horizontal clock enables |
| h_lvl | output | NH | Horizontal clock fixed levels |
| h_min_drive | output | 1 | Horizontal/reset-gate drive at minimum strength |
| hl_oe | output | 1 | HL pin enable |
| hl_lvl | output | 1 | HL pin level |
| rg_oe | output | 1 | Reset-gate enable |
| rg_lvl | output | 1 | Reset-gate level |
| sync_run | output | 1 | VD/HD running |
| sync_lvl | output | 1 | VD/HD level when not running |
| dclk_run | output | 1 | Data clock running (else low) |
| data_low | output | 1 | Data bus held low |
| v_force | output | 1 | Vertical outputs held at v_lvl |
| v_lvl | output | NV | Vertical hold levels |
| gpo_oe | output | NG | GPO enables |
| gpo_force | output | 1 | GPO held at gpo_lvl |
| gpo_lvl | output | NG | GPO hold levels |
| core_rst | output | 1 | One-cycle timing-core reset |
| rst_err | output | 1 | One-cycle early-reset error |

## Verification
The hardest situation to reach is a reset request that lands inside the settling wait. It needs a deep or level-2 standby, then a write of 00, then the 0-then-1 arming sequence on the reset register, all before the counter expires. A second request must then follow after expiry so that both outcomes are seen. The bench shrinks the wait through the frequency parameter and scripts that exact sequence. It then runs random writes over every address with the output-control pin toggling, so that wait reloads during counting and unarmed requests also occur.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    SB_RUN  = 2'b00,
    SB_L1   = 2'b01,
    SB_L2   = 2'b10,
    SB_DEEP = 2'b11
  } sb_lvl_e;

  typedef enum logic [1:0] {
    EFF_NORMAL,
    EFF_LIGHT,
    EFF_OCLOW,
    EFF_DEEP
  } eff_e;

  localparam logic [ADDR_W-1:0] A_STBY   = 3'd0;
  localparam logic [ADDR_W-1:0] A_VPOL_L = 3'd1;
  localparam logic [ADDR_W-1:0] A_VPOL_D = 3'd2;
  localparam logic [ADDR_W-1:0] A_GPOL   = 3'd3;
  localparam logic [ADDR_W-1:0] A_GDIR   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CRST   = 3'd5;
  localparam logic [ADDR_W-1:0] A_SPOL   = 3'd6;
endpackage

// File: rtl/sbc_regs.sv
module sbc_regs
  import sbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NV     = 24,
  parameter int NG     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output sb_lvl_e           sb,
  output logic [NV-1:0]     vpol_lt,
  output logic [NV-1:0]     vpol_dp,
  output logic [NG-1:0]     gpo_pol,
  output logic [NG-1:0]     gpo_dir,
  output logic              sync_pol,
  output logic              exit_slow,
  output logic              req0,
  output logic              req1
);
  logic unused_hi;
  assign unused_hi = ^wr_data;

  logic sel_sb, sel_rst;
  assign sel_sb  = wr_en && (wr_addr == A_STBY);
  assign sel_rst = wr_en && (wr_addr == A_CRST);

  // leaving a level that stopped core or oscillator starts the settle wait
  assign exit_slow = sel_sb && (wr_data[1:0] == 2'b00) && sb[1];
  assign req0      = sel_rst && !wr_data[0];
  assign req1      = sel_rst &&  wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb       <= SB_RUN;
      vpol_lt  <= '0;
      vpol_dp  <= '0;
      gpo_pol  <= '0;
      gpo_dir  <= '0;
      sync_pol <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_STBY:   sb       <= sb_lvl_e'(wr_data[1:0]);
        A_VPOL_L: vpol_lt  <= wr_data[NV-1:0];
        A_VPOL_D: vpol_dp  <= wr_data[NV-1:0];
        A_GPOL:   gpo_pol  <= wr_data[NG-1:0];
        A_GDIR:   gpo_dir  <= wr_data[NG-1:0];
        A_SPOL:   sync_pol <= wr_data[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sbc_settle.sv
module sbc_settle #(
  parameter int SETTLE_CYC = 62500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic req0,
  input  logic req1,
  output logic core_rst,
  output logic rst_err
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt;
  logic          armed;
  logic          busy;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      armed    <= 1'b0;
      core_rst <= 1'b0;
      rst_err  <= 1'b0;
    end else begin
      if (load)      cnt <= CW'(SETTLE_CYC);
      else if (busy) cnt <= cnt - CW'(1);

      core_rst <= req1 && armed && !busy;
      rst_err  <= req1 && armed &&  busy;

      if (req0)      armed <= 1'b1;
      else if (req1) armed <= 1'b0;
    end
  end

  assert_no_reset_while_settling_R7: assert property (
    @(posedge clk) disable iff (!rst_n) busy |=> !core_rst);

  assert_err_excludes_reset_R7: assert property (
    @(posedge clk) disable iff (!rst_n) !(core_rst && rst_err));

  assert_one_shot_R8: assert property (
    @(posedge clk) disable iff (!rst_n) core_rst |=> !core_rst);
endmodule

// File: rtl/sbc_outmux.sv
module sbc_outmux
  import sbc_pkg::*;
#(
  parameter int NH = 8,
  parameter int NV = 24,
  parameter int NG = 6
) (
  input  sb_lvl_e       sb,
  input  logic          out_ctl,
  input  logic [NV-1:0] vpol_lt,
  input  logic [NV-1:0] vpol_dp,
  input  logic [NG-1:0] gpo_pol,
  input  logic [NG-1:0] gpo_dir,
  input  logic          sync_pol,
  output logic          fe_en,
  output logic          tcore_en,
  output logic          osc_en,
  output logic          clko_run,
  output logic [NH-1:0] h_oe,
  output logic [NH-1:0] h_lvl,
  output logic          h_min_drive,
  output logic          hl_oe,
  output logic          hl_lvl,
  output logic          rg_oe,
  output logic          rg_lvl,
  output logic          sync_run,
  output logic          sync_lvl,
  output logic          dclk_run,
  output logic          data_low,
  output logic          v_force,
  output logic [NV-1:0] v_lvl,
  output logic [NG-1:0] gpo_oe,
  output logic          gpo_force,
  output logic [NG-1:0] gpo_lvl
);
  eff_e          eff;
  logic [NH-1:0] alt;

  for (genvar i = 0; i < NH; i++) begin : g_alt
    assign alt[i] = 1'(i % 2);
  end

  always_comb begin
    if (sb == SB_DEEP)   eff = EFF_DEEP;
    else if (!out_ctl)   eff = EFF_OCLOW;
    else if (sb != SB_RUN) eff = EFF_LIGHT;
    else                 eff = EFF_NORMAL;
  end

  // power flags follow the field alone
  assign fe_en    = (sb == SB_RUN);
  assign tcore_en = !sb[1];
  assign osc_en   = (sb != SB_DEEP);
  assign clko_run = osc_en;

  logic fixed_h;
  assign fixed_h = (eff == EFF_LIGHT) || (eff == EFF_OCLOW);

  always_comb begin
    h_oe        = (eff == EFF_DEEP) ? '0 : '1;
    h_lvl       = fixed_h ? alt : '0;
    h_min_drive = fixed_h;
    hl_oe       = (eff != EFF_DEEP);
    hl_lvl      = 1'b0;
    rg_oe       = (eff != EFF_DEEP);
    rg_lvl      = 1'b0;
    sync_run    = (eff == EFF_NORMAL);
    sync_lvl    = (eff == EFF_OCLOW) ? sync_pol : 1'b0;
    dclk_run    = (eff == EFF_NORMAL) || (eff == EFF_OCLOW);
    data_low    = (eff != EFF_NORMAL);
    v_force     = (eff != EFF_NORMAL);
    case (eff)
      EFF_DEEP:   v_lvl = vpol_dp;
      EFF_NORMAL: v_lvl = '0;
      default:    v_lvl = vpol_lt;
    endcase
    gpo_oe    = gpo_dir;
    gpo_force = (eff != EFF_NORMAL);
    gpo_lvl   = (eff == EFF_NORMAL) ? '0 : gpo_pol;
  end
endmodule

// File: rtl/standby_out_ctrl.sv
module standby_out_ctrl
  import sbc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NH        = 8,
  parameter int NV        = 24,
  parameter int NG        = 6,
  parameter int CLK_KHZ   = 125000,
  parameter int SETTLE_US = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              out_ctl,
  output logic              fe_en,
  output logic              tcore_en,
  output logic              osc_en,
  output logic              clko_run,
  output logic [NH-1:0]     h_oe,
  output logic [NH-1:0]     h_lvl,
  output logic              h_min_drive,
  output logic              hl_oe,
  output logic              hl_lvl,
  output logic              rg_oe,
  output logic              rg_lvl,
  output logic              sync_run,
  output logic              sync_lvl,
  output logic              dclk_run,
  output logic              data_low,
  output logic              v_force,
  output logic [NV-1:0]     v_lvl,
  output logic [NG-1:0]     gpo_oe,
  output logic              gpo_force,
  output logic [NG-1:0]     gpo_lvl,
  output logic              core_rst,
  output logic              rst_err
);
  localparam int SETTLE_CYC = CLK_KHZ * SETTLE_US / 1000;

  sb_lvl_e       sb;
  logic [NV-1:0] vpol_lt, vpol_dp;
  logic [NG-1:0] gpo_pol, gpo_dir;
  logic          sync_pol, exit_slow, req0, req1;

  sbc_regs #(.DATA_W(DATA_W), .NV(NV), .NG(NG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sb(sb), .vpol_lt(vpol_lt), .vpol_dp(vpol_dp),
    .gpo_pol(gpo_pol), .gpo_dir(gpo_dir), .sync_pol(sync_pol),
    .exit_slow(exit_slow), .req0(req0), .req1(req1)
  );

  sbc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(exit_slow), .req0(req0),
    .req1(req1), .core_rst(core_rst), .rst_err(rst_err)
  );

  sbc_outmux #(.NH(NH), .NV(NV), .NG(NG)) u_mux (
    .sb(sb), .out_ctl(out_ctl), .vpol_lt(vpol_lt), .vpol_dp(vpol_dp),
    .gpo_pol(gpo_pol), .gpo_dir(gpo_dir), .sync_pol(sync_pol),
    .fe_en(fe_en), .tcore_en(tcore_en), .osc_en(osc_en),
    .clko_run(clko_run), .h_oe(h_oe), .h_lvl(h_lvl),
    .h_min_drive(h_min_drive), .hl_oe(hl_oe), .hl_lvl(hl_lvl),
    .rg_oe(rg_oe), .rg_lvl(rg_lvl), .sync_run(sync_run),
    .sync_lvl(sync_lvl), .dclk_run(dclk_run), .data_low(data_low),
    .v_force(v_force), .v_lvl(v_lvl), .gpo_oe(gpo_oe),
    .gpo_force(gpo_force), .gpo_lvl(gpo_lvl)
  );

  assert_deep_power_off_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    (sb == SB_DEEP) |-> (!fe_en && !tcore_en && !osc_en && !clko_run));

  assert_deep_hiz_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (sb == SB_DEEP) |-> (h_oe == '0 && !hl_oe && !rg_oe && !dclk_run
                         && !sync_run && !sync_lvl && data_low));

  assert_deep_vhold_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (sb == SB_DEEP) |-> (v_force && v_lvl == vpol_dp));

  assert_oc_priority_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (sb != SB_DEEP && !out_ctl) |-> (dclk_run && h_min_drive
                                     && sync_lvl == sync_pol));

  assert_gpo_dir_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_GDIR) |=> (gpo_oe == $past(wr_data[NG-1:0])));
endmodule

// File: tb/sim_standby_out_ctrl.sv
module sim_standby_out_ctrl;
  localparam int NH = 8, NV = 24, NG = 6, DW = 32;
  localparam int KHZ = 40, US = 500;
  localparam int SC  = KHZ * US / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, out_ctl = 1'b1;
  logic [2:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic fe_en, tcore_en, osc_en, clko_run, h_min_drive, hl_oe, hl_lvl;
  logic rg_oe, rg_lvl, sync_run, sync_lvl, dclk_run, data_low, v_force;
  logic gpo_force, core_rst, rst_err;
  logic [NH-1:0] h_oe, h_lvl;
  logic [NV-1:0] v_lvl;
  logic [NG-1:0] gpo_oe, gpo_lvl;

  standby_out_ctrl #(.DATA_W(DW), .NH(NH), .NV(NV), .NG(NG),
                     .CLK_KHZ(KHZ), .SETTLE_US(US)) u0 (.*);

  always #4 clk = ~clk;

  int vecs = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int m_sb, m_wait; bit m_armed, m_pulse, m_err, m_sp;
  logic [NV-1:0] m_vl, m_vd; logic [NG-1:0] m_gp, m_dir;

  task automatic model_reset();
    m_sb = 0; m_wait = 0; m_armed = 0; m_pulse = 0; m_err = 0; m_sp = 0;
    m_vl = '0; m_vd = '0; m_gp = '0; m_dir = '0;
  endtask

  task automatic model_step();
    int old_sb = m_sb;
    m_pulse = 0; m_err = 0;
    if (wr_en && wr_addr == 5) begin
      if (!wr_data[0]) m_armed = 1;
      else begin
        if (m_armed) begin
          if (m_wait == 0) m_pulse = 1; else m_err = 1;
        end
        m_armed = 0;
      end
    end
    if (wr_en && wr_addr == 0 && wr_data[1:0] == 0 && old_sb >= 2) m_wait = SC;
    else if (m_wait > 0) m_wait--;
    if (wr_en) case (wr_addr)
      0: m_sb = int'(wr_data[1:0]);
      1: m_vl = wr_data[NV-1:0];
      2: m_vd = wr_data[NV-1:0];
      3: m_gp = wr_data[NG-1:0];
      4: m_dir = wr_data[NG-1:0];
      6: m_sp = wr_data[0];
      default: ;
    endcase
  endtask

  task automatic compare();
    bit deep = (m_sb == 3);
    bit ocl  = !deep && !out_ctl;
    bit lite = !deep && !ocl && m_sb != 0;
    bit norm = !deep && !ocl && !lite;
    logic [NH-1:0] alt, e_hoe, e_hl;
    string tag;
    for (int i = 0; i < NH; i++) alt[i] = (i % 2 == 1);
    e_hoe = deep ? '0 : '1;
    e_hl  = (lite || ocl) ? alt : '0;
    tag = deep ? "R2 deep pins" : ocl ? "R4 out_ctl low pins" :
          lite ? "R5 light pins" : "R10 normal pins";
    chk("R1 power flags", {fe_en, tcore_en, osc_en, clko_run},
        {m_sb == 0, m_sb <= 1, m_sb != 3, m_sb != 3});
    chk(tag, {h_oe, h_lvl, hl_oe, hl_lvl, rg_oe, rg_lvl, h_min_drive,
              sync_run, sync_lvl, dclk_run, data_low},
        {e_hoe, e_hl, !deep, 1'b0, !deep, 1'b0, lite || ocl,
         norm, ocl && m_sp, norm || ocl, !norm});
    chk("R3 vertical hold", {v_force, v_lvl},
        {!norm, deep ? m_vd : norm ? {NV{1'b0}} : m_vl});
    chk("R6 gpo", {gpo_oe, gpo_force, gpo_lvl},
        {m_dir, !norm, norm ? {NG{1'b0}} : m_gp});
    chk("R7 early reset error", rst_err, m_err);
    chk("R8 core reset pulse", core_rst, m_pulse);
  endtask

  always begin
    @(posedge clk);
    if (!rst_n) model_reset(); else model_step();
    #2;
    if (rst_n && !done) compare();
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_oc(input bit v);
    @(negedge clk); out_ctl = v;
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog expired, act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    model_reset();
    idle(3);
    @(negedge clk) rst_n = 1;
    // reset state at the ports
    chk("R6 gpo_oe after reset", gpo_oe, '0);
    chk("R1 full power after reset", {fe_en, tcore_en, osc_en}, 3'b111);
    wr(1, 32'h00A5_A5A5);
    wr(2, 32'h003C_3C3C);
    wr(3, 32'h0000_002D);
    wr(6, 32'h1);
    // R9: write lands at the accepting edge, not before
    @(negedge clk); wr_en = 1; wr_addr = 3'd0; wr_data = 32'h1;
    #1 chk("R9 before accepting edge", v_force, 1'b0);
    @(negedge clk); wr_en = 0;
    chk("R9 after accepting edge", {v_force, v_lvl}, {1'b1, 24'hA5A5A5});
    idle(2);
    set_oc(0); idle(3); set_oc(1);
    wr(0, 32'h2); set_oc(0); idle(2); set_oc(1);
    wr(0, 32'h3); set_oc(0); idle(2); set_oc(1); idle(2);
    wr(7, 32'hFFFF_FFFF);
    chk("R9 unused address", {v_force, v_lvl}, {1'b1, 24'h3C3C3C});
    // R7: exit deep, then request reset too early
    wr(0, 32'h0);
    wr(5, 32'h0);
    wr(5, 32'h1);
    idle(SC + 4);
    wr(5, 32'h1);          // R8: unarmed request does nothing
    wr(5, 32'h0);
    wr(5, 32'h1);          // R8: accepted after settling
    wr(4, 32'h15);
    wr(0, 32'h2); wr(0, 32'h0); wr(0, 32'h3); wr(0, 32'h0);
    idle(SC + 2);
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      out_ctl = 1'($urandom);
      wr_en   = ($urandom % 3) != 0;
      wr_addr = 3'($urandom);
      wr_data = $urandom;
      if (k % 97 == 0) begin wr_addr = 3'd0; wr_data = 32'h3; end
      if (k % 97 == 1) begin wr_addr = 3'd0; wr_data = 32'h0; end
    end
    @(negedge clk) wr_en = 0;
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule